// File: doc/BRIEF.md
# Masked Interlock Evaluation Logic

This block decides whether a protected radio-frequency station may run. It watches a vector of sampled interlock conditions, one bit per input, where a high level means the condition is healthy. The inputs can be plain status contacts, threshold-compare flags from analog channels, or permit signals that neighbouring subsystems have already evaluated. Examples of such permits are a personnel-safety permit, a leakage detector, a modulator-ready line and an RF-system-ready line. Each input belongs to one of two response classes, set by a parameter. A fast input trips on its first faulty sample. A slow input must stay faulty for a programmable number of consecutive samples before it trips, so that short noise bursts are rejected. Samples are taken on a periodic tick strobe.

A trip on any unmasked input is latched. The latch drops all four enable outputs: modulator, heater supply, solenoid supply and RF drive. The outputs stay off until a clear command is accepted. A clear is refused while any unmasked input still samples faulty, so a hard failure cannot be cleared away. The index of the earliest trip is held for diagnosis. A control system works the block over a synchronous serial link made of a clock, a data-in line, a data-out line and a load strobe. Through this link it reads a snapshot of the sampled inputs, the latches, the outputs and the masks, and it writes the mask register.

Top module: `ilk_eval`

## Requirements
- R1: Reset sets every enable output to 0 and first_valid_o to 0. It sets every fault latch, so the snapshot latch field reads all ones. It clears the mask register, and the snapshot input field reads all zeros until the first tick.
- R2: A clear is accepted only when no unmasked input sampled faulty on the last tick. When it is accepted, every fault latch is cleared and all four enable bits read 1 two clock edges after the clear cycle.
- R3: An input with its class bit set (fast; inputs 0 to 15 by default) sets its latch on the first tick that samples it low. The enable outputs then read 0 one edge later.
- R4: An input with its class bit clear (slow) trips only on the SLOW_SAMPLES-th consecutive faulty tick (default 8). A single healthy tick restarts the count.
- R5: An input whose mask bit is 1 never sets its latch and never blocks a clear.
- R6: A clear given while an unmasked input still samples faulty is ignored, and the enable outputs stay 0.
- R7: first_idx_o records the lowest-numbered input among those tripping on the first tripping tick after a clear. It keeps that value, with first_valid_o at 1, through later trips until a clear is accepted.
- R8: A rising edge on sload_i captures a snapshot of 3*N_IN+4 bits. From MSB to LSB it holds the sampled inputs, the fault latches, the enable outputs (bit 0 is the modulator) and the mask. sdout_o presents the MSB at once and the next bit after each falling sclk_i edge. Rising sclk_i edges shift in sdin_i.
- R9: If exactly 3*N_IN+4 bits were shifted in since the previous strobe, the next strobe loads the low N_IN bits of that frame into the mask, and the snapshot taken at that strobe already shows the new mask. A frame of any other length leaves the mask unchanged.
- R10: A latched fault keeps the outputs off after its input returns healthy, until a clear is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample strobe, one clock wide |
| ok_i | input | N_IN | Interlock conditions, 1 = healthy |
| clear_i | input | 1 | Clear command, one clock wide |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdin_i | input | 1 | Serial data in, sampled on rising sclk_i |
| sload_i | input | 1 | Snapshot / mask-commit strobe |
| sdout_o | output | 1 | Serial data out, MSB first |
| en_o | output | 4 | Enables: bit 0 modulator, 1 heater, 2 solenoid, 3 RF |
| first_valid_o | output | 1 | A first fault is recorded |
| first_idx_o | output | $clog2(N_IN) | Index of the first tripping input |

## Verification
Single faulty samples on a fast input and on a slow input show the two response classes apart. Runs of seven and then eight faulty ticks on a slow input mark the persistence boundary exactly. Two simultaneous fast faults followed by a later third one separate the priority ordering from the hold behaviour of the first-fault record. A clear given with the fault still present, with the fault gone, and with only a masked input still faulty shows that the clear is gated by unmasked inputs only. Full-length and one-short serial frames show that the mask loads only from a complete frame.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // Enable output positions
  localparam int unsigned N_EN    = 4;
  localparam int unsigned EN_MOD  = 0;
  localparam int unsigned EN_HEAT = 1;
  localparam int unsigned EN_SOL  = 2;
  localparam int unsigned EN_RF   = 3;
endpackage

// File: rtl/ilk_chan_bank.sv
module ilk_chan_bank #(
  parameter int N_IN = 48,
  parameter int SLOW_SAMPLES = 8,
  parameter logic [N_IN-1:0] FAST_CLASS = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic [N_IN-1:0] ok_i,
  input  logic [N_IN-1:0] mask_i,
  input  logic            clr_acc_i,
  output logic [N_IN-1:0] samp_o,
  output logic [N_IN-1:0] lat_o,
  output logic [N_IN-1:0] trip_o,
  output logic            blocked_o
);
  localparam int CW = $clog2(SLOW_SAMPLES + 1);

  logic [N_IN-1:0] trip;

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_ch
      if (FAST_CLASS[g]) begin : g_fast
        assign trip[g] = tick_i & ~ok_i[g] & ~mask_i[g];
      end else begin : g_slow
        logic [CW-1:0] run;
        always_ff @(posedge clk) begin
          if (rst) begin
            run <= '0;
          end else if (tick_i) begin
            if (ok_i[g])
              run <= '0;
            else if (run != CW'(SLOW_SAMPLES))
              run <= run + 1'b1;
          end
        end
        assign trip[g] = tick_i & ~ok_i[g] & ~mask_i[g] &
                         (run >= CW'(SLOW_SAMPLES - 1));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_o <= '0;
      lat_o  <= '1;
    end else begin
      if (tick_i) samp_o <= ok_i;
      lat_o <= (clr_acc_i ? '0 : lat_o) | trip;
    end
  end

  assign trip_o    = trip;
  assign blocked_o = |(~samp_o & ~mask_i);

  // R5: a masked input never raises its latch
  a_r5_masked_no_latch: assert property (@(posedge clk) disable iff (rst)
    ((lat_o & ~$past(lat_o) & $past(mask_i)) == '0));
endmodule

// File: rtl/ilk_first_fault.sv
module ilk_first_fault #(
  parameter int N_IN = 48,
  localparam int IW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] trip_i,
  input  logic            clr_acc_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic [IW-1:0] pick;
  logic          any;

  always_comb begin
    pick = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (trip_i[i]) pick = IW'(i);
    end
  end
  assign any = |trip_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else if (any && (!valid_o || clr_acc_i)) begin
      valid_o <= 1'b1;
      idx_o   <= pick;
    end else if (clr_acc_i) begin
      valid_o <= 1'b0;
    end
  end

  // R7: record is held until an accepted clear
  a_r7_first_held: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !clr_acc_i) |=> (valid_o && $stable(idx_o)));
endmodule

// File: rtl/ilk_serial.sv
module ilk_serial #(
  parameter int N_IN = 48,
  parameter int W = 148
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              sload_i,
  input  logic [W-N_IN-1:0] state_i,
  output logic [N_IN-1:0]   mask_o,
  output logic              sdout_o
);
  localparam int BW = $clog2(W + 2);

  logic [2:0]    sclk_q, sload_q;
  logic [1:0]    sdin_q;
  logic          sclk_rise, sclk_fall, load_rise, commit;
  logic [W-1:0]  shreg;
  logic [BW-1:0] bcnt;
  logic [N_IN-1:0] mask_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= '0;
      sload_q <= '0;
      sdin_q  <= '0;
    end else begin
      sclk_q  <= {sclk_q[1:0], sclk_i};
      sload_q <= {sload_q[1:0], sload_i};
      sdin_q  <= {sdin_q[0], sdin_i};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] & sclk_q[2];
  assign load_rise = sload_q[1] & ~sload_q[2];
  assign commit    = (bcnt == BW'(W));
  assign mask_nx   = commit ? shreg[N_IN-1:0] : mask_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bcnt    <= '0;
      mask_o  <= '0;
      sdout_o <= 1'b0;
    end else if (load_rise) begin
      mask_o  <= mask_nx;
      shreg   <= {state_i, mask_nx};
      sdout_o <= state_i[W-N_IN-1];
      bcnt    <= '0;
    end else if (sclk_rise) begin
      shreg <= {shreg[W-2:0], sdin_q[1]};
      if (bcnt != BW'(W + 1)) bcnt <= bcnt + 1'b1;
    end else if (sclk_fall) begin
      sdout_o <= shreg[W-1];
    end
  end

  // R9: mask only changes at a load strobe
  a_r9_mask_only_at_load: assert property (@(posedge clk) disable iff (rst)
    !load_rise |=> $stable(mask_o));
endmodule

// File: rtl/ilk_eval.sv
module ilk_eval #(
  parameter int N_IN = 48,
  parameter int SLOW_SAMPLES = 8,
  parameter logic [N_IN-1:0] FAST_CLASS = N_IN'(16'hFFFF),
  localparam int IW = $clog2(N_IN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_i,
  input  logic [N_IN-1:0]           ok_i,
  input  logic                      clear_i,
  input  logic                      sclk_i,
  input  logic                      sdin_i,
  input  logic                      sload_i,
  output logic                      sdout_o,
  output logic [ilk_pkg::N_EN-1:0]  en_o,
  output logic                      first_valid_o,
  output logic [IW-1:0]             first_idx_o
);
  localparam int NE = ilk_pkg::N_EN;
  localparam int W  = 3 * N_IN + NE;

  logic [N_IN-1:0] mask, samp, lat, trip;
  logic            blocked, clr_acc;

  assign clr_acc = clear_i & ~blocked;

  ilk_chan_bank #(.N_IN(N_IN), .SLOW_SAMPLES(SLOW_SAMPLES), .FAST_CLASS(FAST_CLASS)) u_bank (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ok_i(ok_i), .mask_i(mask),
    .clr_acc_i(clr_acc), .samp_o(samp), .lat_o(lat), .trip_o(trip),
    .blocked_o(blocked)
  );

  ilk_first_fault #(.N_IN(N_IN)) u_first (
    .clk(clk), .rst(rst), .trip_i(trip), .clr_acc_i(clr_acc),
    .valid_o(first_valid_o), .idx_o(first_idx_o)
  );

  ilk_serial #(.N_IN(N_IN), .W(W)) u_ser (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdin_i(sdin_i), .sload_i(sload_i),
    .state_i({samp, lat, en_o}), .mask_o(mask), .sdout_o(sdout_o)
  );

  always_ff @(posedge clk) begin
    if (rst) en_o <= '0;
    else     en_o <= {NE{~|lat}};
  end

  // R1: outputs off right after reset
  a_r1_reset_off: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_o == '0));
  // R3: any latched fault forces the enables off next cycle
  a_r3_latch_drops_en: assert property (@(posedge clk) disable iff (rst)
    (|lat) |=> (en_o == '0));
  // R2: enables only on when no latch was set
  a_r2_en_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (en_o != '0) |-> ($past(lat) == '0));
  // R6: a blocked clear does not empty the latches
  a_r6_blocked_clear: assert property (@(posedge clk) disable iff (rst)
    (clear_i && blocked && (|lat)) |=> (|lat));
endmodule

// File: tb/tb_ilk_eval.sv
module tb_ilk_eval;
  localparam int N  = 48;
  localparam int NE = 4;
  localparam int W  = 3 * N + NE;
  localparam int IW = $clog2(N);

  logic clk = 0, rst = 1, tick = 0, clr = 0, sclk = 0, sdin = 0, sload = 0;
  logic [N-1:0] ok = '1;
  logic sdout, fvalid;
  logic [NE-1:0] en;
  logic [IW-1:0] fidx;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ilk_eval dut (
    .clk(clk), .rst(rst), .tick_i(tick), .ok_i(ok), .clear_i(clr),
    .sclk_i(sclk), .sdin_i(sdin), .sload_i(sload), .sdout_o(sdout),
    .en_o(en), .first_valid_o(fvalid), .first_idx_o(fidx)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic [N-1:0] v);
    @(negedge clk); ok = v; tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    @(negedge clk);
  endtask

  task automatic frame(input logic [N-1:0] wmask, input int nbits, output logic [W-1:0] rd);
    logic [W-1:0] fw;
    fw = {{(W-N){1'b0}}, wmask};
    rd = '0;
    @(negedge clk); sload = 1; repeat (4) @(negedge clk);
    sload = 0; repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      rd[W-1-b] = sdout;
      sdin = fw[W-1-b];
      @(negedge clk); sclk = 1; repeat (4) @(negedge clk);
      sclk = 0; repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic [N-1:0] one_low(input int i);
    logic [N-1:0] v;
    v = '1; v[i] = 1'b0;
    return v;
  endfunction

  task automatic t_reset();
    logic [W-1:0] rd;
    check("R1 en after reset", W'(en), W'(4'h0));
    check("R1 first_valid after reset", W'(fvalid), W'(0));
    frame('0, W, rd);
    check("R1/R8 reset snapshot", rd, {{N{1'b0}}, {N{1'b1}}, 4'h0, {N{1'b0}}});
  endtask

  task automatic t_bringup();
    logic [W-1:0] rd;
    do_tick('1);
    do_clear();
    check("R2 en after accepted clear", W'(en), W'(4'hF));
    check("R2 first_valid cleared", W'(fvalid), W'(0));
    frame('0, W, rd);
    check("R8 steady snapshot", rd, {{N{1'b1}}, {N{1'b0}}, 4'hF, {N{1'b0}}});
  endtask

  task automatic t_fast();
    do_tick(one_low(3));
    check("R3 fast trip en", W'(en), W'(4'h0));
    check("R7 first idx fast", W'({fvalid, fidx}), W'({1'b1, 6'd3}));
    do_tick('1);
    @(negedge clk);
    check("R10 latch holds after recovery", W'(en), W'(4'h0));
    do_clear();
    check("R2 clear after fast recovery", W'(en), W'(4'hF));
  endtask

  task automatic t_slow();
    for (int k = 0; k < 7; k++) do_tick(one_low(20));
    check("R4 slow 7 samples no trip", W'(en), W'(4'hF));
    do_tick('1);
    for (int k = 0; k < 7; k++) do_tick(one_low(20));
    check("R4 slow count restarted", W'(en), W'(4'hF));
    do_tick(one_low(20));
    check("R4 slow 8th sample trips", W'(en), W'(4'h0));
    check("R7 first idx slow", W'({fvalid, fidx}), W'({1'b1, 6'd20}));
    do_tick('1);
    do_clear();
    check("R2 clear after slow", W'(en), W'(4'hF));
  endtask

  task automatic t_priority();
    logic [N-1:0] v;
    v = '1; v[9] = 1'b0; v[4] = 1'b0;
    do_tick(v);
    check("R7 lowest simultaneous index", W'({fvalid, fidx}), W'({1'b1, 6'd4}));
    do_tick(one_low(2));
    check("R7 index held over later trip", W'({fvalid, fidx}), W'({1'b1, 6'd4}));
    do_tick('1);
    do_clear();
    check("R2 clear after priority", W'(en), W'(4'hF));
  endtask

  task automatic t_blocked();
    do_tick(one_low(6));
    do_clear();
    check("R6 clear ignored while faulty", W'(en), W'(4'h0));
    check("R6 first record kept", W'({fvalid, fidx}), W'({1'b1, 6'd6}));
    do_tick('1);
    do_clear();
    check("R6 clear accepted once healthy", W'(en), W'(4'hF));
  endtask

  task automatic t_mask();
    logic [W-1:0] rd;
    logic [N-1:0] m7, v;
    m7 = '0; m7[7] = 1'b1;
    frame(m7, W, rd);
    frame(m7, W, rd);
    check("R9 mask loaded from full frame", W'(rd[N-1:0]), W'(m7));
    for (int k = 0; k < 3; k++) do_tick(one_low(7));
    check("R5 masked input no trip", W'(en), W'(4'hF));
    v = one_low(7); v[2] = 1'b0;
    do_tick(v);
    check("R3 unmasked trip with masked fault", W'(en), W'(4'h0));
    do_tick(one_low(7));
    do_clear();
    check("R5 masked fault does not block clear", W'(en), W'(4'hF));
    do_tick('1);
    frame('0, W - 1, rd);
    frame('0, W, rd);
    check("R9 short frame leaves mask", W'(rd[N-1:0]), W'(m7));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_bringup();
    t_fast();
    t_slow();
    t_priority();
    t_blocked();
    t_mask();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule